// File: doc/BRIEF.md
# Sprite Attribute Memory with Scan-Conflict Corruption

This block holds the sprite attribute table of an LCD controller: 160 bytes that the CPU reads and writes one byte at a time, while the sprite scanner reads whole 8-byte rows through a separate port. CPU accesses are controlled by the controller's current mode. While pixels are being fetched, a CPU access is refused without any other effect. While the scanner is walking the table, a CPU access corrupts the row being scanned in a fixed bitwise way.

The table is organised as 20 rows of four 16-bit words. The row under scan during the sprite scan phase is the dot count divided by four. Each corruption is a single-cycle update of one to three rows. Every operand is sampled before any row is written. A separate read strobe selects the heavier corruption pattern that occurs when the CPU read coincides with a pointer increment.

Top module: `spr_attr_mem`

## Requirements
- R1: Byte j (0..7) of row r sits at CPU address 8r+j. Word k of a row is {byte 2k+1, byte 2k}. With `lcd_on` low, or in mode 0 (H-Blank) or mode 1 (V-Blank), a write stores the byte and a read returns the stored byte on `cpu_rdata` one cycle after the strobe.
- R2: In mode 3 (pixel fetch) with `lcd_on` high, a read returns 0xFF, a write is dropped, and no row changes.
- R3: In mode 2 (sprite scan) with `lcd_on` high, the row under scan is `dot`/4, and any CPU read returns 0xFF.
- R4: A write during scan discards its data. Word 0 of row n becomes ((a^c)&(b^c))^c, where a is word 0 of row n, b is word 0 of row n-1, and c is word 2 of row n-1. Words 1..3 of row n are copied from row n-1.
- R5: A plain read during scan sets word 0 of row n to b|(a&c), using the same operands as R4, and copies words 1..3 from row n-1.
- R6: Row 0 is never corrupted. Plain read and write corruption leave row n-1 unchanged.
- R7: An increment-read (`cpu_rd_inc`) during scan on rows 4..18 first computes w = (b&(a|c|d))|(a&c&d). Here a is word 0 of row n-2, b is word 0 of row n-1, c is word 0 of row n, and d is word 2 of row n-1. Word 0 of row n-1 becomes w. The updated row n-1 is copied into rows n-2 and n. Plain read corruption (R5) is then applied to row n.
- R8: An increment-read during scan on rows 1..3 or row 19 applies only plain read corruption.
- R9: Outside the scan and fetch restrictions, an address of 160 or above reads 0xFF and a write to it changes nothing.
- R10: Outside mode 2, `cpu_rd_inc` behaves exactly like `cpu_rd`.
- R11: `scan_data` always shows the current 64-bit image of row `scan_row`, with byte j in bits 8j+7..8j.
- R12: Reset clears every byte of the table and `cpu_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcd_on | input | 1 | LCD enable; when low, all access restrictions are lifted |
| mode | input | 2 | Controller mode: 0 H-Blank, 1 V-Blank, 2 scan, 3 fetch |
| dot | input | 9 | Dot count within the line |
| cpu_addr | input | 8 | CPU byte address into the table |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd_inc | input | 1 | CPU read strobe coinciding with a pointer increment |
| cpu_rdata | output | 8 | Registered CPU read data |
| scan_row | input | 5 | Row index for the scanner port |
| scan_data | output | 64 | Row image for the scanner |

## Verification
The assertions assume that at most one CPU strobe is active in any cycle. They also assume that `dot` stays below 80 whenever `mode` is 2 with the LCD on, so every scan access maps onto a real row. The stimulus drives one strobe per access and clears it on the following cycle. For scan accesses it only chooses dot values of the form 4n+k with n in 0..19. The mode, dot and enable inputs are held steady around each access, so the expected row contents depend only on the access order.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int ROW_BYTES = 8;
  localparam int ROW_WORDS = 4;

  typedef logic [15:0] word_t;
  typedef logic [8*ROW_BYTES-1:0] row_t;

  typedef enum logic [1:0] {
    MD_HBLANK = 2'd0,
    MD_VBLANK = 2'd1,
    MD_SCAN   = 2'd2,
    MD_FETCH  = 2'd3
  } lcd_mode_e;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD,
    ACC_WR,
    ACC_DENY_RD,
    ACC_DENY_WR,
    ACC_GL_RD,
    ACC_GL_WR,
    ACC_GL_INC
  } acc_kind_e;

  function automatic word_t row_word(input row_t r, input int k);
    return r[16*k +: 16];
  endfunction

  // write-conflict rule for word 0
  function automatic word_t glitch_wr(input word_t a, input word_t b, input word_t c);
    return ((a ^ c) & (b ^ c)) ^ c;
  endfunction

  // read-conflict rule for word 0
  function automatic word_t glitch_rd(input word_t a, input word_t b, input word_t c);
    return b | (a & c);
  endfunction

  // increment-read rule for word 0 of the preceding row
  function automatic word_t glitch_inc(input word_t a, input word_t b,
                                       input word_t c, input word_t d);
    return (b & (a | c | d)) | (a & c & d);
  endfunction

  function automatic row_t rebuild_wr(input row_t cur, input row_t prv);
    return {prv[63:16], glitch_wr(row_word(cur, 0), row_word(prv, 0), row_word(prv, 2))};
  endfunction

  function automatic row_t rebuild_rd(input row_t cur, input row_t prv);
    return {prv[63:16], glitch_rd(row_word(cur, 0), row_word(prv, 0), row_word(prv, 2))};
  endfunction
endpackage

// File: rtl/spr_acc_decode.sv
module spr_acc_decode
  import spr_pkg::*;
#(
  parameter int NUM_ROWS = 20,
  parameter int ADDR_W   = 8,
  parameter int DOT_W    = 9,
  localparam int RIDX_W  = $clog2(NUM_ROWS),
  localparam int MEM_BYTES = NUM_ROWS * ROW_BYTES
) (
  input  logic              lcd_on,
  input  logic [1:0]        mode,
  input  logic [DOT_W-1:0]  dot,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              rd_inc,
  output acc_kind_e         kind,
  output logic [RIDX_W-1:0] scan_idx
);
  int   scan_ln;
  logic scan_ok;
  logic addr_ok;
  logic any_rd;

  always_comb begin
    scan_ln  = int'(dot) / 4;
    scan_ok  = scan_ln < NUM_ROWS;
    addr_ok  = int'(addr) < MEM_BYTES;
    any_rd   = rd | rd_inc;
    scan_idx = scan_ok ? RIDX_W'(scan_ln) : '0;
    kind     = ACC_NONE;
    if (lcd_on && lcd_mode_e'(mode) == MD_SCAN) begin
      if (wr)          kind = scan_ok ? ACC_GL_WR  : ACC_DENY_WR;
      else if (rd_inc) kind = scan_ok ? ACC_GL_INC : ACC_DENY_RD;
      else if (rd)     kind = scan_ok ? ACC_GL_RD  : ACC_DENY_RD;
    end else if (lcd_on && lcd_mode_e'(mode) == MD_FETCH) begin
      if (wr)          kind = ACC_DENY_WR;
      else if (any_rd) kind = ACC_DENY_RD;
    end else begin
      if (wr)          kind = addr_ok ? ACC_WR : ACC_DENY_WR;
      else if (any_rd) kind = addr_ok ? ACC_RD : ACC_DENY_RD;
    end
  end
endmodule

// File: rtl/spr_glitch_unit.sv
module spr_glitch_unit
  import spr_pkg::*;
#(
  parameter int NUM_ROWS = 20,
  localparam int RIDX_W  = $clog2(NUM_ROWS)
) (
  input  acc_kind_e         kind,
  input  logic [RIDX_W-1:0] row_idx,
  input  row_t              row_m2,
  input  row_t              row_m1,
  input  row_t              row_n,
  output row_t              new_m2,
  output row_t              new_m1,
  output row_t              new_n,
  output logic              upd_m2,
  output logic              upd_m1,
  output logic              upd_n
);
  row_t  m1_upd;
  word_t inc_w0;
  logic  deep_row;

  always_comb begin
    deep_row = (int'(row_idx) >= 4) && (int'(row_idx) <= NUM_ROWS - 2);
    inc_w0   = glitch_inc(row_word(row_m2, 0), row_word(row_m1, 0),
                          row_word(row_n, 0), row_word(row_m1, 2));
    m1_upd   = {row_m1[63:16], inc_w0};
    new_m2 = row_m2;
    new_m1 = row_m1;
    new_n  = row_n;
    upd_m2 = 1'b0;
    upd_m1 = 1'b0;
    upd_n  = 1'b0;
    if (row_idx != '0) begin
      unique case (kind)
        ACC_GL_WR: begin
          new_n = rebuild_wr(row_n, row_m1);
          upd_n = 1'b1;
        end
        ACC_GL_RD: begin
          new_n = rebuild_rd(row_n, row_m1);
          upd_n = 1'b1;
        end
        ACC_GL_INC: begin
          if (deep_row) begin
            new_m2 = m1_upd;
            new_m1 = m1_upd;
            new_n  = rebuild_rd(m1_upd, m1_upd);
            upd_m2 = 1'b1;
            upd_m1 = 1'b1;
          end else begin
            new_n  = rebuild_rd(row_n, row_m1);
          end
          upd_n = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spr_attr_mem.sv
module spr_attr_mem
  import spr_pkg::*;
#(
  parameter int NUM_ROWS = 20,
  parameter int ADDR_W   = 8,
  parameter int DOT_W    = 9,
  localparam int RIDX_W  = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcd_on,
  input  logic [1:0]        mode,
  input  logic [DOT_W-1:0]  dot,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_rd_inc,
  output logic [7:0]        cpu_rdata,
  input  logic [RIDX_W-1:0] scan_row,
  output logic [63:0]       scan_data
);
  acc_kind_e         kind;
  logic [RIDX_W-1:0] row_idx;
  row_t              rows_w [NUM_ROWS];
  row_t              row_m2, row_m1, row_n;
  row_t              new_m2, new_m1, new_n;
  logic              upd_m2, upd_m1, upd_n;
  int                idx_n, idx_m1, idx_m2;
  int                wr_row, wr_lane;

  // named events for the checker
  logic byte_we;
  logic glitch_any;
  row_t row0_img;

  function automatic row_t pick_row(input row_t arr [NUM_ROWS], input int idx);
    row_t r;
    r = '0;
    for (int i = 0; i < NUM_ROWS; i++)
      if (i == idx) r = arr[i];
    return r;
  endfunction

  spr_acc_decode #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W), .DOT_W(DOT_W)) u_dec (
    .lcd_on   (lcd_on),
    .mode     (mode),
    .dot      (dot),
    .addr     (cpu_addr),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .rd_inc   (cpu_rd_inc),
    .kind     (kind),
    .scan_idx (row_idx)
  );

  always_comb begin
    idx_n   = int'(row_idx);
    idx_m1  = idx_n - 1;
    idx_m2  = idx_n - 2;
    row_n   = pick_row(rows_w, idx_n);
    row_m1  = pick_row(rows_w, idx_m1);
    row_m2  = pick_row(rows_w, idx_m2);
    wr_row  = int'(cpu_addr) / ROW_BYTES;
    wr_lane = int'(cpu_addr) % ROW_BYTES;
  end

  spr_glitch_unit #(.NUM_ROWS(NUM_ROWS)) u_glitch (
    .kind    (kind),
    .row_idx (row_idx),
    .row_m2  (row_m2),
    .row_m1  (row_m1),
    .row_n   (row_n),
    .new_m2  (new_m2),
    .new_m1  (new_m1),
    .new_n   (new_n),
    .upd_m2  (upd_m2),
    .upd_m1  (upd_m1),
    .upd_n   (upd_n)
  );

  assign byte_we    = (kind == ACC_WR);
  assign glitch_any = upd_n | upd_m1 | upd_m2;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    row_t q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (upd_n && idx_n == g) begin
        q <= new_n;
      end else if (upd_m1 && idx_m1 == g) begin
        q <= new_m1;
      end else if (upd_m2 && idx_m2 == g) begin
        q <= new_m2;
      end else if (byte_we && wr_row == g) begin
        q[8*wr_lane +: 8] <= cpu_wdata;
      end
    end
    assign rows_w[g] = q;
  end

  assign row0_img = rows_w[0];

  row_t rd_img;
  always_comb rd_img = pick_row(rows_w, wr_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= 8'h00;
    end else begin
      unique case (kind)
        ACC_RD:                                  cpu_rdata <= rd_img[8*wr_lane +: 8];
        ACC_DENY_RD, ACC_GL_RD, ACC_GL_INC:      cpu_rdata <= 8'hFF;
        default: ;
      endcase
    end
  end

  assign scan_data = pick_row(rows_w, int'(scan_row));
endmodule

// File: rtl/spr_attr_mem_chk.sv
module spr_attr_mem_chk #(
  parameter int NUM_ROWS = 20,
  parameter int ADDR_W   = 8,
  parameter int DOT_W    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lcd_on,
  input logic [1:0]        mode,
  input logic [DOT_W-1:0]  dot,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              cpu_rd_inc,
  input logic [7:0]        cpu_rdata,
  input logic              byte_we,
  input logic              glitch_any,
  input logic [63:0]       row0_img
);
  logic any_strobe;
  assign any_strobe = cpu_rd | cpu_wr | cpu_rd_inc;

  // R2
  fetch_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd3 && any_strobe) |-> (!byte_we && !glitch_any));

  // R2
  fetch_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd3 && (cpu_rd || cpu_rd_inc) && !cpu_wr) |=> (cpu_rdata == 8'hFF));

  // R3
  scan_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd2 && (cpu_rd || cpu_rd_inc) && !cpu_wr) |=> (cpu_rdata == 8'hFF));

  // R4
  scan_wr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd2 && cpu_wr) |-> !byte_we);

  // R6
  row0_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd2 && int'(dot) < 4 && any_strobe) |=> $stable(row0_img));

  // R1
  idle_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_on && cpu_wr && int'(cpu_addr) < NUM_ROWS * 8) |-> byte_we);
endmodule

bind spr_attr_mem spr_attr_mem_chk #(
  .NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W), .DOT_W(DOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lcd_on     (lcd_on),
  .mode       (mode),
  .dot        (dot),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .cpu_rd_inc (cpu_rd_inc),
  .cpu_rdata  (cpu_rdata),
  .byte_we    (byte_we),
  .glitch_any (glitch_any),
  .row0_img   (row0_img)
);

// File: tb/spr_attr_mem_tb.sv
module spr_attr_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lcd_on = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [8:0]  dot = '0;
  logic [7:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd_inc = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [4:0]  scan_row = '0;
  logic [63:0] scan_data;

  int n_vec = 0;
  int n_bad = 0;
  logic rd_issued = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mdl [160];

  always #4 clk = ~clk;

  spr_attr_mem dut_i (
    .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .mode(mode), .dot(dot),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_rd_inc(cpu_rd_inc), .cpu_rdata(cpu_rdata), .scan_row(scan_row),
    .scan_data(scan_data)
  );

  // ---------------- model ----------------
  function automatic logic [15:0] mw(int r, int k);
    return {mdl[8*r + 2*k + 1], mdl[8*r + 2*k]};
  endfunction
  task automatic set_mw(int r, int k, logic [15:0] v);
    mdl[8*r + 2*k]     = v[7:0];
    mdl[8*r + 2*k + 1] = v[15:8];
  endtask
  task automatic copy_row(int src, int dst);
    for (int j = 0; j < 8; j++) mdl[8*dst + j] = mdl[8*src + j];
  endtask
  task automatic m_wr_glitch(int r);
    logic [15:0] a, b, c;
    if (r == 0) return;
    a = mw(r, 0); b = mw(r-1, 0); c = mw(r-1, 2);
    for (int k = 1; k < 4; k++) set_mw(r, k, mw(r-1, k));
    set_mw(r, 0, (a & b) | (c & (a | b)));
  endtask
  task automatic m_rd_glitch(int r);
    logic [15:0] a, b, c;
    if (r == 0) return;
    a = mw(r, 0); b = mw(r-1, 0); c = mw(r-1, 2);
    for (int k = 1; k < 4; k++) set_mw(r, k, mw(r-1, k));
    set_mw(r, 0, b | (a & c));
  endtask
  task automatic m_inc_glitch(int r);
    logic [15:0] a, b, c, d, nb;
    if (r == 0) return;
    if (r >= 4 && r <= 18) begin
      a = mw(r-2, 0); b = mw(r-1, 0); c = mw(r, 0); d = mw(r-1, 2);
      for (int i = 0; i < 16; i++)
        nb[i] = b[i] ? (a[i] | c[i] | d[i]) : (a[i] & c[i] & d[i]);
      set_mw(r-1, 0, nb);
      copy_row(r-1, r-2);
      copy_row(r-1, r);
    end
    m_rd_glitch(r);
  endtask

  // ---------------- monitor ----------------
  always @(posedge clk) rd_issued <= rst_n && (cpu_rd || cpu_rd_inc);

  always @(negedge clk) begin
    if (rd_issued) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (cpu_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: cpu_rdata=%02h expected=%02h", t, cpu_rdata, e);
      end
    end
  end

  // ---------------- driver ----------------
  // kind: 0 read, 1 write, 2 increment-read
  task automatic access(int kind, logic l_on, logic [1:0] md, int dt,
                        logic [7:0] a, logic [7:0] wd, logic [7:0] exp, string tag);
    lcd_on = l_on; mode = md; dot = 9'(dt);
    cpu_addr = a; cpu_wdata = wd;
    cpu_rd = (kind == 0); cpu_wr = (kind == 1); cpu_rd_inc = (kind == 2);
    if (kind != 1) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_rd_inc = 1'b0;
  endtask

  task automatic check_row(int r, string tag);
    for (int j = 0; j < 8; j++)
      access(0, 1'b1, 2'd0, 300, 8'(8*r + j), 8'h00, mdl[8*r + j], tag);
  endtask

  task automatic check_scan_port(int r, string tag);
    logic [63:0] e;
    for (int j = 0; j < 8; j++) e[8*j +: 8] = mdl[8*r + j];
    scan_row = 5'(r);
    #1;
    n_vec++;
    if (scan_data !== e) begin
      n_bad++;
      $display("FAIL %s: scan_data=%016h expected=%016h", tag, scan_data, e);
    end
  endtask

  initial begin
    for (int i = 0; i < 160; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R12: reset state
    n_vec++;
    if (cpu_rdata !== 8'h00) begin
      n_bad++;
      $display("FAIL R12: cpu_rdata=%02h expected=00", cpu_rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 1'b1, 2'd0, 300, 8'h25, 8'h00, 8'h00, "R12 cleared byte");

    // R1: fill with LCD off while mode reads scan
    for (int i = 0; i < 160; i++) begin
      mdl[i] = 8'((i * 37 + 11) & 8'hFF);
      access(1, 1'b0, 2'd2, 20, 8'(i), mdl[i], 8'h00, "R1");
    end
    access(0, 1'b1, 2'd0, 300, 8'h00, 8'h00, mdl[0],   "R1 hblank read");
    access(0, 1'b1, 2'd1, 300, 8'h9F, 8'h00, mdl[159], "R1 vblank read");
    access(0, 1'b0, 2'd3, 90,  8'h47, 8'h00, mdl[71],  "R1 lcd off read");
    access(1, 1'b1, 2'd1, 300, 8'h40, 8'hC3, 8'h00, "R1");
    mdl[64] = 8'hC3;
    access(0, 1'b1, 2'd0, 300, 8'h40, 8'h00, mdl[64], "R1 vblank write");

    // R11: scanner port
    check_scan_port(3, "R11 row 3");
    check_scan_port(19, "R11 row 19");

    // R2: fetch mode blocks
    access(1, 1'b1, 2'd3, 120, 8'h0A, 8'h5A, 8'h00, "R2");
    access(0, 1'b1, 2'd3, 120, 8'h0A, 8'h00, 8'hFF, "R2 fetch read");
    access(0, 1'b1, 2'd0, 300, 8'h0A, 8'h00, mdl[10], "R2 write dropped");

    // R4: write glitch on row 7
    access(1, 1'b1, 2'd2, 4*7+1, 8'h03, 8'hEE, 8'h00, "R4");
    m_wr_glitch(7);
    check_row(7, "R4 row 7");
    check_row(6, "R6 prev row after write");

    // R3/R5: read glitch on row 9
    access(0, 1'b1, 2'd2, 4*9+3, 8'h48, 8'h00, 8'hFF, "R3 scan read");
    m_rd_glitch(9);
    check_row(9, "R5 row 9");
    check_row(8, "R6 prev row after read");

    // R6: row 0 immune
    access(1, 1'b1, 2'd2, 2, 8'h01, 8'h77, 8'h00, "R6");
    access(0, 1'b1, 2'd2, 0, 8'h01, 8'h00, 8'hFF, "R3 row 0 read");
    check_row(0, "R6 row 0");

    // R7: increment-read on row 12
    access(2, 1'b1, 2'd2, 4*12, 8'h10, 8'h00, 8'hFF, "R3 inc read");
    m_inc_glitch(12);
    check_row(10, "R7 row n-2");
    check_row(11, "R7 row n-1");
    check_row(12, "R7 row n");
    check_row(13, "R7 row n+1");
    check_scan_port(11, "R11 row 11 after inc");

    // R8: increment-read on rows 2 and 19
    access(2, 1'b1, 2'd2, 4*2+2, 8'h00, 8'h00, 8'hFF, "R8 row 2");
    m_inc_glitch(2);
    check_row(0, "R8 row 0");
    check_row(2, "R8 row 2");
    access(2, 1'b1, 2'd2, 4*19+3, 8'h00, 8'h00, 8'hFF, "R8 row 19");
    m_inc_glitch(19);
    check_row(17, "R8 row 17");
    check_row(19, "R8 row 19");

    // R10: increment strobe outside scan
    access(2, 1'b1, 2'd0, 300, 8'h33, 8'h00, mdl[51], "R10 hblank");
    access(2, 1'b0, 2'd2, 10,  8'h34, 8'h00, mdl[52], "R10 lcd off");

    // R9: out of range
    access(1, 1'b0, 2'd0, 0, 8'hB0, 8'hA5, 8'h00, "R9");
    access(0, 1'b0, 2'd0, 0, 8'hB0, 8'h00, 8'hFF, "R9 out of range");
    for (int r = 0; r < 20; r++) check_scan_port(r, "R9 table unchanged");

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule